// File: doc/BRIEF.md
# Half-Precision Lane Compare Unit

This block compares two binary16 floating-point operands and returns a 16-bit lane mask. The mask is all ones when the selected relation holds and all zeros when it does not. A five-bit opcode picks the relation. The relations are equality, greater-or-equal, greater-than, and the greater-or-equal and greater-than forms taken on magnitudes with the sign bits ignored. The result is registered, so it appears one clock after a valid request. A vector datapath can place one instance per lane and combine the masks with bitwise select operations.

Two exception conditions are collected in sticky status bits: invalid operation and input denormal. The equality test is quiet and flags only signaling NaNs. The ordered tests flag any NaN. The status bits hold until a dedicated clear input is raised. An opcode outside the five supported codes returns a zero mask and raises a one-cycle illegal-opcode pulse. Such a request leaves the status bits unchanged.

Top module: `fp16_cmp_unit`

## Requirements
- R1: Opcodes select the relation as follows: 0x04 equality, 0x14 greater-or-equal, 0x1C greater-than, 0x15 magnitude greater-or-equal, 0x1D magnitude greater-than.
- R2: A true relation gives res_mask = 0xFFFF and a false relation gives 0x0000. No other value appears on res_mask.
- R3: A NaN operand is one with exponent bits [14:10] all ones and a nonzero fraction [9:0]. When either operand is a NaN, the result is 0x0000 for every opcode.
- R4: +0 (0x0000) and -0 (0x8000) are equal. Between them, greater-or-equal is true and greater-than is false.
- R5: Non-NaN values are ordered by sign first (bit 15), then by bits [14:0] read as an unsigned magnitude. The magnitude order is reversed when both operands are negative. Infinities take part in this ordering as ordinary values.
- R6: The two magnitude opcodes clear bit 15 of both operands before they compare.
- R7: Equality is quiet. It raises the invalid flag only when an operand is a signaling NaN, which is a NaN with bit 9 clear.
- R8: Greater-or-equal, greater-than and both magnitude opcodes raise the invalid flag for any NaN operand, quiet or signaling.
- R9: On a supported opcode, any subnormal operand (exponent zero, fraction nonzero) raises the input-denormal flag.
- R10: An unsupported opcode gives res_mask = 0x0000 and raises illegal_op for exactly one cycle. It changes neither status flag.
- R11: A request accepted with in_valid updates res_mask and pulses res_valid high on the next clock edge. With no request, res_valid is low and res_mask holds its value.
- R12: The status flags are sticky. Only flag_clr resets them, and clear takes priority over a flag raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request qualifier |
| opcode | input | 5 | Relation select |
| op_a | input | 16 | First binary16 operand |
| op_b | input | 16 | Second binary16 operand |
| flag_clr | input | 1 | Clears the sticky status flags |
| res_valid | output | 1 | Result present this cycle |
| res_mask | output | 16 | Lane mask result |
| illegal_op | output | 1 | Unsupported opcode seen on the last request |
| stat_invalid | output | 1 | Sticky invalid-operation flag |
| stat_denorm | output | 1 | Sticky input-denormal flag |

## Verification
Operand pairs cover several cases. Equal values, neighbouring values and mixed-sign values separate the equality, greater-or-equal and greater-than relations. Pairs of negative operands show whether the magnitude order is reversed. A negative operand with a larger magnitude than a positive one separates the signed opcodes from the magnitude opcodes. Signed zeros, infinities and subnormals test the edges of the ordering. Quiet and signaling NaNs are sent on both the quiet and the signaling opcodes to show which of them sets the invalid flag. Illegal opcodes carrying NaN and subnormal operands confirm that the status bits stay untouched.

// File: rtl/fp16_cmp_unit.sv
module fp16_cmp_unit #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int OPC_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic               flag_clr,
  output logic               res_valid,
  output logic [EXP_W+MAN_W:0] res_mask,
  output logic               illegal_op,
  output logic               stat_invalid,
  output logic               stat_denorm
);
  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int SGN = W - 1;
  localparam logic [OPC_W-1:0] OP_EQ  = OPC_W'(5'h04);
  localparam logic [OPC_W-1:0] OP_GE  = OPC_W'(5'h14);
  localparam logic [OPC_W-1:0] OP_AGE = OPC_W'(5'h15);
  localparam logic [OPC_W-1:0] OP_GT  = OPC_W'(5'h1c);
  localparam logic [OPC_W-1:0] OP_AGT = OPC_W'(5'h1d);

  logic legal, use_abs, want_eq, want_gt, quiet;

  always_comb begin
    legal   = 1'b1;
    use_abs = 1'b0;
    want_eq = 1'b0;
    want_gt = 1'b0;
    quiet   = 1'b0;
    unique case (opcode)
      OP_EQ:  begin want_eq = 1'b1; quiet = 1'b1; end
      OP_GE:  begin want_eq = 1'b1; want_gt = 1'b1; end
      OP_AGE: begin want_eq = 1'b1; want_gt = 1'b1; use_abs = 1'b1; end
      OP_GT:  want_gt = 1'b1;
      OP_AGT: begin want_gt = 1'b1; use_abs = 1'b1; end
      default: legal = 1'b0;
    endcase
  end

  logic [W-1:0] xa, xb;
  assign xa = use_abs ? {1'b0, op_a[SGN-1:0]} : op_a;
  assign xb = use_abs ? {1'b0, op_b[SGN-1:0]} : op_b;

  logic sa, sb;
  logic [SGN-1:0] ma, mb;
  assign sa = xa[SGN];
  assign sb = xb[SGN];
  assign ma = xa[SGN-1:0];
  assign mb = xb[SGN-1:0];

  logic nan_a, nan_b, snan_a, snan_b, sub_a, sub_b;
  assign nan_a  = (&xa[SGN-1:MAN_W]) && (|xa[MAN_W-1:0]);
  assign nan_b  = (&xb[SGN-1:MAN_W]) && (|xb[MAN_W-1:0]);
  assign snan_a = nan_a && !xa[MAN_W-1];
  assign snan_b = nan_b && !xb[MAN_W-1];
  assign sub_a  = (xa[SGN-1:MAN_W] == '0) && (|xa[MAN_W-1:0]);
  assign sub_b  = (xb[SGN-1:MAN_W] == '0) && (|xb[MAN_W-1:0]);

  logic unord, zeros, rel_eq, rel_gt, mag_gt, hit;
  assign unord  = nan_a || nan_b;
  assign zeros  = (ma == '0) && (mb == '0);
  assign mag_gt = sa ? (ma < mb) : (ma > mb);
  assign rel_eq = !unord && ((xa == xb) || zeros);
  assign rel_gt = !unord && !zeros && ((sa != sb) ? !sa : mag_gt);
  assign hit    = legal && ((want_eq && rel_eq) || (want_gt && rel_gt));

  logic raise_inv, raise_den;
  assign raise_inv = in_valid && legal && (quiet ? (snan_a || snan_b) : unord);
  assign raise_den = in_valid && legal && (sub_a || sub_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_mask   <= '0;
      illegal_op <= 1'b0;
    end else begin
      res_valid  <= in_valid;
      illegal_op <= in_valid && !legal;
      if (in_valid) res_mask <= {W{hit}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_invalid <= 1'b0;
      stat_denorm  <= 1'b0;
    end else if (flag_clr) begin
      stat_invalid <= 1'b0;
      stat_denorm  <= 1'b0;
    end else begin
      stat_invalid <= stat_invalid || raise_inv;
      stat_denorm  <= stat_denorm || raise_den;
    end
  end
endmodule

module fp16_cmp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  opcode,
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic        flag_clr,
  input logic        res_valid,
  input logic [15:0] res_mask,
  input logic        illegal_op,
  input logic        stat_invalid,
  input logic        stat_denorm
);
  logic any_nan;
  assign any_nan = ((op_a[14:10] == 5'h1f) && (op_a[9:0] != '0)) ||
                   ((op_b[14:10] == 5'h1f) && (op_b[9:0] != '0));

  AST_MASK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mask == 16'h0000) || (res_mask == 16'hffff)); // R2
  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && any_nan |=> res_mask == 16'h0000); // R3
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> res_valid && res_mask == 16'h0000); // R10
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op && !in_valid |=> !illegal_op); // R10
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid && $stable(res_mask)); // R11
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr && stat_invalid |=> stat_invalid); // R12
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !stat_invalid && !stat_denorm); // R12
endmodule

bind fp16_cmp_unit fp16_cmp_unit_chk u_chk (.*);

// File: tb/tb_fp16_cmp_unit.sv
module tb_fp16_cmp_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] opcode = '0;
  logic [15:0] op_a = '0, op_b = '0;
  logic flag_clr = 1'b0;
  logic res_valid, illegal_op, stat_invalid, stat_denorm;
  logic [15:0] res_mask;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [4:0] EQ = 5'h04, GE = 5'h14, AGE = 5'h15, GT = 5'h1c, AGT = 5'h1d;
  localparam logic [15:0] ONE = 16'h3c00, TWO = 16'h4000, M1 = 16'hbc00, M2 = 16'hc000;
  localparam logic [15:0] PZ = 16'h0000, NZ = 16'h8000, QN = 16'h7e00, SN = 16'h7c01;
  localparam logic [15:0] INF = 16'h7c00, DEN = 16'h0001, T = 16'hffff, F = 16'h0000;

  always #4 clk = ~clk;

  fp16_cmp_unit dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cmp(input string req, input logic [4:0] op, input logic [15:0] a,
                     input logic [15:0] b, input logic [15:0] exp_v);
    issue(op, a, b);
    chk(req, res_mask, exp_v);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset valid", {15'd0, res_valid}, 16'd0);
    chk("R11 reset mask", res_mask, F);
    chk("R12 reset flags", {14'd0, stat_invalid, stat_denorm}, 16'd0);
    chk("R10 reset illegal", {15'd0, illegal_op}, 16'd0);
  endtask

  task automatic t_relations();
    cmp("R1 eq same", EQ, ONE, ONE, T);
    cmp("R1 eq diff", EQ, ONE, TWO, F);
    cmp("R1 ge greater", GE, TWO, ONE, T);
    cmp("R1 ge equal", GE, ONE, ONE, T);
    cmp("R1 ge less", GE, ONE, TWO, F);
    cmp("R1 gt equal", GT, ONE, ONE, F);
    cmp("R2 gt greater", GT, TWO, ONE, T);
  endtask

  task automatic t_order();
    cmp("R5 neg pair gt", GT, M2, M1, F);
    cmp("R5 neg pair gt rev", GT, M1, M2, T);
    cmp("R5 mixed sign", GT, ONE, M2, T);
    cmp("R5 mixed sign rev", GE, M1, ONE, F);
    cmp("R5 inf", GT, INF, TWO, T);
    cmp("R4 zeros eq", EQ, PZ, NZ, T);
    cmp("R4 zeros ge", GE, NZ, PZ, T);
    cmp("R4 zeros gt", GT, PZ, NZ, F);
  endtask

  task automatic t_abs();
    cmp("R6 agt neg big", AGT, M2, ONE, T);
    cmp("R6 signed gt same pair", GT, M2, ONE, F);
    cmp("R6 age equal mag", AGE, M1, ONE, T);
    cmp("R6 agt equal mag", AGT, ONE, M1, F);
  endtask

  task automatic t_nan_flags();
    clear_flags();
    cmp("R3 eq qnan", EQ, QN, QN, F);
    chk("R7 eq qnan quiet", {15'd0, stat_invalid}, 16'd0);
    cmp("R3 eq snan", EQ, ONE, SN, F);
    chk("R7 eq snan signals", {15'd0, stat_invalid}, 16'd1);
    clear_flags();
    cmp("R3 ge qnan", GE, QN, ONE, F);
    chk("R8 ge qnan signals", {15'd0, stat_invalid}, 16'd1);
    clear_flags();
    cmp("R3 agt neg qnan", AGT, 16'hfe00, ONE, F);
    chk("R8 agt qnan signals", {15'd0, stat_invalid}, 16'd1);
    chk("R9 no denorm", {15'd0, stat_denorm}, 16'd0);
  endtask

  task automatic t_denorm();
    clear_flags();
    cmp("R9 denorm gt zero", GT, DEN, PZ, T);
    chk("R9 denorm flag", {15'd0, stat_denorm}, 16'd1);
    chk("R9 invalid untouched", {15'd0, stat_invalid}, 16'd0);
  endtask

  task automatic t_illegal();
    clear_flags();
    cmp("R2 prime true", GE, ONE, ONE, T);
    cmp("R10 illegal mask", 5'h02, SN, DEN, F);
    chk("R10 illegal pulse", {15'd0, illegal_op}, 16'd1);
    chk("R10 flags unchanged", {14'd0, stat_invalid, stat_denorm}, 16'd0);
    @(negedge clk);
    chk("R10 pulse ends", {15'd0, illegal_op}, 16'd0);
    cmp("R10 legal after", EQ, ONE, ONE, T);
    chk("R10 legal no pulse", {15'd0, illegal_op}, 16'd0);
  endtask

  task automatic t_latency();
    issue(GT, TWO, ONE);
    chk("R11 valid pulse", {15'd0, res_valid}, 16'd1);
    chk("R11 mask", res_mask, T);
    @(negedge clk);
    chk("R11 valid drops", {15'd0, res_valid}, 16'd0);
    chk("R11 mask holds", res_mask, T);
  endtask

  task automatic t_sticky();
    clear_flags();
    cmp("R12 set", GE, SN, ONE, F);
    cmp("R12 clean op", EQ, ONE, ONE, T);
    chk("R12 stays set", {15'd0, stat_invalid}, 16'd1);
    @(negedge clk);
    flag_clr = 1'b1; in_valid = 1'b1; opcode = GT; op_a = QN; op_b = DEN;
    @(negedge clk);
    flag_clr = 1'b0; in_valid = 1'b0;
    chk("R12 clear wins", {14'd0, stat_invalid, stat_denorm}, 16'd0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_relations();
    t_order();
    t_abs();
    t_nan_flags();
    t_denorm();
    t_illegal();
    t_latency();
    t_sticky();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule